// File: doc/BRIEF.md
# ATM Cell Slave Receive Port

This block is the receive side of a slave on a shared, cell-oriented 8-bit bus. Up to 31 such slaves can sit on the bus. On every rising edge of the master's receive clock it takes in the data byte, the start-of-cell strobe, the receive enable and the 5-bit slave address that the master drives. When the master polls the slave's own configured address, the slave answers on a shared cell-available flag. The flag is high only when the downstream store has room for a whole 53-byte cell.

Bytes are taken only in cycles that follow a cycle in which the enable was high. A cell opens on the byte that comes with the start strobe. Its 53rd accepted byte closes it. The accepted bytes leave the block as a local stream with a valid signal, a first-byte marker and a last-byte marker. A start strobe inside a cell throws away the partial cell, raises a one-cycle error pulse and opens a new cell. The shared flag is a tri-state signal. It is delivered as a value and an output enable for the pad driver, and the enable is raised only while this slave is the addressed one. Address 31 is the null address and selects no slave. A port-enable configuration input takes the whole port out of service.

Top module: `atm_rx_slave`

## Requirements
- R1: A byte is accepted at a clock edge only if the receive enable was high at the previous edge and the port is enabled. The byte and the start strobe are taken from the edge at which the byte is accepted. Each accepted byte appears on `out_data` with `out_valid` high one edge later.
- R2: A byte accepted together with the start strobe is output with `out_first` high. Bytes accepted while no cell is open and without the strobe are dropped, so `out_valid` stays low for them.
- R3: The 53rd accepted byte of a cell is output with `out_last` high, and the cell is then closed. Later bytes without a start strobe are dropped.
- R4: While the enable is low, acceptance pauses and the byte position within the cell is kept. After the pause, the cell still ends with `out_last` on its 53rd accepted byte.
- R5: If the start strobe is accepted while a cell is open, the new byte is output with both `out_first` and `out_err` high. The partial cell is abandoned, and counting restarts so that this byte is position 1 of 53.
- R6: One edge after a poll, `clav` is 1 if `free_slots` was at least 53 at the polling edge, and 0 otherwise.
- R7: `clav_oe` is high one edge after an edge at which `rx_addr` equalled `my_addr`, `rx_addr` was not 31, and `port_en` was high. In every other case `clav_oe` is low.
- R8: While `port_en` is low, no byte is accepted, `clav_oe` is low and any open cell is discarded. After the port is enabled again, bytes without a start strobe are dropped.
- R9: After reset, `out_valid`, `out_first`, `out_last`, `out_err`, `clav` and `clav_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock driven by the master |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Configuration: 1 puts the port in service |
| my_addr | input | 5 | Configured slave address |
| rx_addr | input | 5 | Slave address driven by the master (31 = null) |
| rx_enb | input | 1 | Receive enable from the master, active high |
| rx_soc | input | 1 | Start-of-cell strobe |
| rx_data | input | 8 | Receive data byte |
| free_slots | input | 8 | Free byte slots in the downstream store |
| clav | output | 1 | Cell-available value |
| clav_oe | output | 1 | Output enable for the shared cell-available pad |
| out_valid | output | 1 | Accepted byte present on `out_data` |
| out_data | output | 8 | Accepted byte |
| out_first | output | 1 | First byte of a cell |
| out_last | output | 1 | 53rd byte of a cell |
| out_err | output | 1 | Start strobe arrived inside an open cell |

## Verification
The byte path is driven in five patterns: a continuous cell, a cell with the enable dropped partway, a cell broken by an early start strobe, bytes with no strobe at all, and a cell cut by a port disable. The continuous cell puts a strobe in the first enable cycle. That strobe is ignored, which separates the one-cycle sampling delay from sampling at once. The continuous cell also places the last marker exactly on byte 53 and checks that the following byte is dropped. The paused cell separates a kept position from a reset or skipped one. The broken cell checks that the error pulse comes with the new first byte and that the count restarts. Polls step the free space across the 52/53 boundary and try a foreign address and the null address, which separates correct flag and drive-enable decoding from an off-by-one or a missing null check.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NULL_ADDR = (1 << ADDR_W) - 1;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic              last;
        logic              err;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;
endpackage

// File: rtl/atm_rx_poll.sv
module atm_rx_poll
    import atm_rx_pkg::*;
#(
    parameter int CELL_LEN = 53,
    parameter int FREE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [FREE_W-1:0] free_slots,
    output logic              clav,
    output logic              clav_oe
);
    localparam logic [FREE_W-1:0] NEED = FREE_W'(CELL_LEN);
    localparam logic [ADDR_W-1:0] NULLA = ADDR_W'(NULL_ADDR);

    typedef struct packed {
        logic sel;
        logic room;
    } poll_t;

    poll_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = port_en && (rx_addr == my_addr) && (rx_addr != NULLA);
        st_d.room = (free_slots >= NEED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clav    = st_q.room;
    assign clav_oe = st_q.sel;

    // R7: the null address never produces a drive enable
    assert_null_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clav_oe |-> ($past(rx_addr) != NULLA));

    // R6: a high flag implies room for a whole cell at the poll edge
    assert_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clav |-> ($past(free_slots) >= NEED));
endmodule

// File: rtl/atm_rx_align.sv
module atm_rx_align
    import atm_rx_pkg::*;
#(
    parameter int CELL_LEN = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              rx_enb,
    input  logic              rx_soc,
    input  logic [BYTE_W-1:0] rx_data,
    output rx_byte_t          out_byte
);
    localparam int CNT_W = $clog2(CELL_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CELL_LEN - 1);

    typedef struct packed {
        logic             enb;
        logic [CNT_W-1:0] cnt;   // 0 = no open cell, else bytes taken so far
        rx_byte_t         ob;
    } algn_t;

    algn_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ob  = '0;
        st_d.enb = port_en & rx_enb;
        if (!port_en) begin
            st_d.cnt = '0;
        end else if (st_q.enb) begin
            if (rx_soc) begin
                st_d.ob.valid = 1'b1;
                st_d.ob.first = 1'b1;
                st_d.ob.err   = (st_q.cnt != '0);
                st_d.ob.data  = rx_data;
                st_d.cnt      = CNT_W'(1);
            end else if (st_q.cnt != '0) begin
                st_d.ob.valid = 1'b1;
                st_d.ob.data  = rx_data;
                if (st_q.cnt == LAST_POS) begin
                    st_d.ob.last = 1'b1;
                    st_d.cnt     = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.ob;

    // R5: an error pulse only ever comes with a new first byte
    assert_err_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_byte.err |-> (out_byte.valid && out_byte.first));

    // R3: a cell never opens and closes on the same byte
    assert_first_not_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_byte.valid |-> !(out_byte.first && out_byte.last));
endmodule

// File: rtl/atm_rx_slave.sv
module atm_rx_slave
    import atm_rx_pkg::*;
#(
    parameter int CELL_LEN = 53,
    parameter int FREE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [4:0]        my_addr,
    input  logic [4:0]        rx_addr,
    input  logic              rx_enb,
    input  logic              rx_soc,
    input  logic [7:0]        rx_data,
    input  logic [FREE_W-1:0] free_slots,
    output logic              clav,
    output logic              clav_oe,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_err
);
    rx_byte_t ob;

    atm_rx_poll #(.CELL_LEN(CELL_LEN), .FREE_W(FREE_W)) u_poll (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .my_addr(my_addr),
        .rx_addr(rx_addr), .free_slots(free_slots),
        .clav(clav), .clav_oe(clav_oe)
    );

    atm_rx_align #(.CELL_LEN(CELL_LEN)) u_align (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_enb(rx_enb),
        .rx_soc(rx_soc), .rx_data(rx_data), .out_byte(ob)
    );

    assign out_valid = ob.valid;
    assign out_data  = ob.data;
    assign out_first = ob.first;
    assign out_last  = ob.last;
    assign out_err   = ob.err;

    // R1: an output byte needs the enable two edges back, while enabled
    assert_enb_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(rx_enb, 2) && $past(port_en)));

    // R8: a disabled port never drives the shared flag
    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clav_oe |-> $past(port_en));
endmodule

// File: tb/atm_rx_slave_test.sv
module atm_rx_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1;
    logic [4:0] my_addr = 5'd3;
    logic [4:0] rx_addr = 5'd0;
    logic       rx_enb = 1'b0;
    logic       rx_soc = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] free_slots = 8'd0;
    logic       clav, clav_oe, out_valid, out_first, out_last, out_err;
    logic [7:0] out_data;
    int         n_run = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    atm_rx_slave uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .my_addr(my_addr),
        .rx_addr(rx_addr), .rx_enb(rx_enb), .rx_soc(rx_soc), .rx_data(rx_data),
        .free_slots(free_slots), .clav(clav), .clav_oe(clav_oe),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_err(out_err)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one cycle, then check the registered byte output of that edge
    task automatic push(input logic enb, input logic soc, input logic [7:0] d,
                        input logic ev, input logic ef, input logic el,
                        input logic ee, input string tag);
        logic [3:0] act, exp;
        rx_enb = enb; rx_soc = soc; rx_data = d;
        tick;
        act = {out_valid, out_first, out_last, out_err};
        exp = {ev, ef, el, ee};
        chk(act == exp, {tag, " flags"}, int'(act), int'(exp));
        if (ev) chk(out_data == d, {tag, " data"}, int'(out_data), int'(d));
    endtask

    task automatic idle;
        push(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "idle");
        push(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "idle");
    endtask

    task automatic t_reset;
        chk({out_valid, out_first, out_last, out_err, clav, clav_oe} == 6'b0,
            "R9 reset", int'({out_valid, out_first, out_last, out_err, clav, clav_oe}), 0);
    endtask

    task automatic poll(input logic [4:0] a, input logic [7:0] fs,
                        input logic eoe, input logic ecl, input string tag);
        rx_addr = a; free_slots = fs;
        tick;
        chk(clav_oe == eoe, {tag, " oe"}, int'(clav_oe), int'(eoe));
        if (eoe) chk(clav == ecl, {tag, " clav"}, int'(clav), int'(ecl));
    endtask

    task automatic t_poll;
        my_addr = 5'd3;
        poll(5'd3, 8'd100, 1'b1, 1'b1, "R6 room");
        poll(5'd3, 8'd53, 1'b1, 1'b1, "R6 exact");
        poll(5'd3, 8'd52, 1'b1, 1'b0, "R6 short");
        poll(5'd4, 8'd100, 1'b0, 1'b0, "R7 foreign");
        my_addr = 5'd31;
        poll(5'd31, 8'd100, 1'b0, 1'b0, "R7 null");
        my_addr = 5'd3;
        rx_addr = 5'd0;
    endtask

    // R1 R2 R3: strobe in the first enable cycle is ignored, cell of 53
    task automatic t_full;
        push(1'b1, 1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, "R1 first enb cycle");
        for (int i = 0; i < 53; i++)
            push(1'b1, i == 0, 8'(8'h10 + i), 1'b1, i == 0, i == 52, 1'b0, "R2 R3 cell");
        push(1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, "R3 after last");
        idle;
    endtask

    task automatic t_pause;
        push(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 start");
        for (int i = 0; i < 10; i++)
            push(1'b1, i == 0, 8'(8'h40 + i), 1'b1, i == 0, 1'b0, 1'b0, "R4 pre");
        push(1'b0, 1'b0, 8'h4A, 1'b1, 1'b0, 1'b0, 1'b0, "R1 enb drop edge");
        push(1'b0, 1'b0, 8'hBB, 1'b0, 1'b0, 1'b0, 1'b0, "R4 paused");
        push(1'b1, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0, 1'b0, "R1 enb return");
        for (int i = 11; i < 53; i++)
            push(1'b1, 1'b0, 8'(8'h40 + i), 1'b1, 1'b0, i == 52, 1'b0, "R4 post");
        push(1'b0, 1'b0, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, "R4 closed");
        idle;
    endtask

    task automatic t_resync;
        push(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R5 start");
        for (int i = 0; i < 20; i++)
            push(1'b1, i == 0, 8'(8'h80 + i), 1'b1, i == 0, 1'b0, 1'b0, "R5 partial");
        push(1'b1, 1'b1, 8'hC0, 1'b1, 1'b1, 1'b0, 1'b1, "R5 early strobe");
        for (int i = 1; i < 53; i++)
            push(1'b1, 1'b0, 8'(8'hC0 + i), 1'b1, 1'b0, i == 52, 1'b0, "R5 restart");
        idle;
    endtask

    task automatic t_nosoc;
        push(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R2 start");
        for (int i = 0; i < 5; i++)
            push(1'b1, 1'b0, 8'(8'h20 + i), 1'b0, 1'b0, 1'b0, 1'b0, "R2 no strobe");
        idle;
    endtask

    task automatic t_disable;
        push(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R8 start");
        for (int i = 0; i < 10; i++)
            push(1'b1, i == 0, 8'(8'h60 + i), 1'b1, i == 0, 1'b0, 1'b0, "R8 pre");
        port_en = 1'b0;
        rx_addr = my_addr; free_slots = 8'd100;
        push(1'b1, 1'b1, 8'h6A, 1'b0, 1'b0, 1'b0, 1'b0, "R8 off strobe");
        push(1'b1, 1'b0, 8'h6B, 1'b0, 1'b0, 1'b0, 1'b0, "R8 off byte");
        chk(clav_oe == 1'b0, "R8 off oe", int'(clav_oe), 0);
        port_en = 1'b1;
        push(1'b1, 1'b0, 8'h6C, 1'b0, 1'b0, 1'b0, 1'b0, "R8 on first");
        push(1'b1, 1'b0, 8'h6D, 1'b0, 1'b0, 1'b0, 1'b0, "R8 cell cleared");
        rx_addr = 5'd0;
        idle;
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset;
        #30;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_poll;
        t_full;
        t_pause;
        t_resync;
        t_nosoc;
        t_disable;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule